// File: doc/BRIEF.md
# Programmable SPI Master Core

This block is an SPI master driven through a two-address write port. One address holds a 32-bit configuration word. The other address loads the shift register and starts a transfer. The core divides the system clock to make SCLK. It presents outgoing bits on MOSI, samples MISO on the capture edge, and drives a chip-select pattern. It reports busy while a transfer runs, and the shift register is readable at all times as the received word.

The configuration word has four byte-wide fields. Bits 7:0 are flags, bits 15:8 hold the bit count minus one, bits 23:16 hold the divider minus two, and bits 31:24 hold the select pattern. The flag bits are:

| Bit | Name | Effect when set |
|-----|------|-----------------|
| 0 | end | release select when the transfer finishes |
| 1 | lsb | shift LSB first |
| 2 | cpol | SCLK idles high |
| 3 | cpha | data is captured on the trailing edge |

Without the end flag, the core parks with select still asserted. The next data write then runs a chained transfer that has no lead-in period. A write that arrives while a transfer runs is discarded and raises a one-cycle error strobe.

Top module: `spi_master_core`

## Requirements
- R1: After reset the configuration is length 1, divider 2, select pattern 0 and all flags clear. Configuration fields sit at flags[7:0], length-1[15:8], divider-2[23:16] and select[31:24].
- R2: Each bit period lasts div system cycles. Its setup half is the first ceil(div/2) cycles and its hold half is the remaining floor(div/2) cycles. SCLK is at the active level (not cpol) during the hold half when cpha=0, and during the setup half when cpha=1.
- R3: A data write from idle keeps busy high for exactly (n+1)*div cycles: one lead-in period followed by n bit periods. It produces exactly n leading SCLK edges.
- R4: MSB-first (lsb=0) sends data[31], data[30], and so on. LSB-first (lsb=1) sends data[0], data[1], and so on. MOSI is stable at the capture edge, which is the leading edge for cpha=0 and the trailing edge for cpha=1.
- R5: Each MISO bit captured on the capture edge enters the shift register at the end opposite the output end. With MISO looped back from MOSI and n=32, the data register returns the written word unchanged.
- R6: A write to either address while busy is high changes neither the configuration nor the data register. It raises busy_err for exactly the following cycle.
- R7: A transfer without the end flag leaves the select pattern asserted with busy low. A data write in that state starts at once and is busy for n*div cycles. The select pattern stays on the sel_o output throughout.
- R8: When a transfer with the end flag finishes, sel_o returns to all zeros.
- R9: done is high for exactly one cycle, the first cycle in which busy is low after a transfer.
- R10: Whenever no bit period is running, SCLK sits at the cpol level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = data/start, 1 = configuration |
| wr_data | input | DATA_W | Write value |
| miso | input | 1 | Serial data from the slave |
| rd_data | output | DATA_W | Shift register contents / received word |
| busy | output | 1 | Transfer in progress |
| busy_err | output | 1 | One-cycle strobe for a write dropped while busy |
| done | output | 1 | One-cycle strobe at the end of each transfer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| sel_o | output | CS_W | Active-high chip-select pattern |

## Verification
On every cycle, the assertions check four things:
- The error strobe only follows a write made while busy.
- done is a single cycle that lines up with the fall of busy.
- SCLK rests at its polarity level outside a transfer.
- The select pattern is driven for the whole of every transfer.

Some behaviour depends on counting and on data, and only the bench scenarios can show it. This covers the exact (n+1)*div and n*div durations, the split of each SCLK period for odd dividers, the bit order seen at the capture edge, and the received word after rotation through a looped-back MISO. It also covers the fact that a dropped write leaves the following transfer's length and divider unchanged.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
   localparam int CFG_W = 32;
   localparam int FLD_W = 8;

   localparam int FLAG_END  = 0;
   localparam int FLAG_LSB  = 1;
   localparam int FLAG_CPOL = 2;
   localparam int FLAG_CPHA = 3;

   localparam int LEN_LSB = 8;
   localparam int DIV_LSB = 16;
   localparam int SEL_LSB = 24;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_PARK = 2'd2
   } seq_state_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int FLD_W = 8,
   localparam int CNT_W = FLD_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [FLD_W-1:0] div_m2,
   output logic             hold_start,
   output logic             period_end,
   output logic             in_hold
);
   logic [CNT_W-1:0] div_full;
   logic [CNT_W-1:0] half_len;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] cnt_q;

   assign div_full = {1'b0, div_m2} + CNT_W'(2);
   assign half_len = (div_full + CNT_W'(1)) >> 1;
   assign last_cnt = div_full - CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == last_cnt) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign in_hold    = (cnt_q >= half_len);
   assign hold_start = run && (cnt_q == half_len);
   assign period_end = run && (cnt_q == last_cnt);
endmodule

// File: rtl/spi_seq.sv
module spi_seq
   import spi_core_pkg::*;
#(
   parameter int FLD_W = 8,
   localparam int PER_W = FLD_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             end_flag,
   input  logic [FLD_W-1:0] len_m1,
   input  logic             hold_start,
   input  logic             period_end,
   output seq_state_t       state,
   output logic             bit_phase,
   output logic             sample_en,
   output logic             shift_en,
   output logic             xfer_done
);
   seq_state_t       state_q;
   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] n_bits;
   logic             done_q;

   assign n_bits = {1'b0, len_m1} + PER_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         per_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: if (start) begin
               state_q <= SEQ_RUN;
               per_q   <= '0;
            end
            SEQ_PARK: if (start) begin
               state_q <= SEQ_RUN;
               per_q   <= PER_W'(1);
            end
            SEQ_RUN: if (period_end) begin
               if (per_q == n_bits) begin
                  done_q  <= 1'b1;
                  per_q   <= '0;
                  state_q <= end_flag ? SEQ_IDLE : SEQ_PARK;
               end else begin
                  per_q <= per_q + PER_W'(1);
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign state     = state_q;
   assign bit_phase = (state_q == SEQ_RUN) && (per_q != '0);
   assign sample_en = bit_phase && hold_start;
   assign shift_en  = bit_phase && period_end;
   assign xfer_done = done_q;
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              sample_en,
   input  logic              shift_en,
   input  logic              lsb_first,
   input  logic              miso,
   output logic [DATA_W-1:0] sr,
   output logic              mosi
);
   logic [DATA_W-1:0] sr_q;
   logic              cap_q;
   logic              bit_in;

   // A divider of 2 samples and shifts in the same cycle.
   assign bit_in = sample_en ? miso : cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cap_q <= 1'b0;
      end else begin
         if (sample_en) cap_q <= miso;
         if (load) begin
            sr_q <= load_val;
         end else if (shift_en) begin
            if (lsb_first) sr_q <= {bit_in, sr_q[DATA_W-1:1]};
            else           sr_q <= {sr_q[DATA_W-2:0], bit_in};
         end
      end
   end

   assign sr   = sr_q;
   assign mosi = lsb_first ? sr_q[0] : sr_q[DATA_W-1];
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
   import spi_core_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CS_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              miso,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              busy_err,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   output logic [CS_W-1:0]   sel_o
);
   if (DATA_W != CFG_W) begin : g_bad_width
      $error("DATA_W must equal the 32-bit word size");
   end
   if (CS_W < 1 || CS_W > FLD_W) begin : g_bad_sel
      $error("CS_W must be between 1 and 8");
   end

   logic             end_q, lsb_q, cpol_q, cpha_q;
   logic [FLD_W-1:0] len_q, div_q;
   logic [CS_W-1:0]  cs_q;
   logic             err_q;
   logic             accept, cfg_wr, data_wr;
   seq_state_t       state;
   logic             bit_phase, sample_en, shift_en, xfer_done;
   logic             hold_start, period_end, in_hold;
   logic             active_lvl;
   logic             unused_bits;

   assign busy    = (state == SEQ_RUN);
   assign accept  = wr_en && !busy;
   assign cfg_wr  = accept && wr_addr;
   assign data_wr = accept && !wr_addr;

   assign unused_bits = ^{wr_data[7:4], wr_data[DATA_W-1:SEL_LSB+CS_W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         end_q  <= 1'b0;
         lsb_q  <= 1'b0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         len_q  <= '0;
         div_q  <= '0;
         cs_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= wr_en && busy;
         if (cfg_wr) begin
            end_q  <= wr_data[FLAG_END];
            lsb_q  <= wr_data[FLAG_LSB];
            cpol_q <= wr_data[FLAG_CPOL];
            cpha_q <= wr_data[FLAG_CPHA];
            len_q  <= wr_data[LEN_LSB +: FLD_W];
            div_q  <= wr_data[DIV_LSB +: FLD_W];
            cs_q   <= wr_data[SEL_LSB +: CS_W];
         end
      end
   end

   spi_clk_div #(.FLD_W(FLD_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .div_m2(div_q),
      .hold_start(hold_start), .period_end(period_end), .in_hold(in_hold)
   );

   spi_seq #(.FLD_W(FLD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(data_wr), .end_flag(end_q),
      .len_m1(len_q), .hold_start(hold_start), .period_end(period_end),
      .state(state), .bit_phase(bit_phase), .sample_en(sample_en),
      .shift_en(shift_en), .xfer_done(xfer_done)
   );

   spi_shift_reg #(.DATA_W(DATA_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .load(data_wr), .load_val(wr_data),
      .sample_en(sample_en), .shift_en(shift_en), .lsb_first(lsb_q),
      .miso(miso), .sr(rd_data), .mosi(mosi)
   );

   assign active_lvl = bit_phase && (cpha_q ? !in_hold : in_hold);
   assign sclk       = cpol_q ^ active_lvl;
   assign busy_err   = err_q;
   assign done       = xfer_done;

   for (genvar i = 0; i < CS_W; i++) begin : g_sel
      assign sel_o[i] = (state != SEQ_IDLE) && cs_q[i];
   end
endmodule

// File: rtl/spi_master_core_chk.sv
module spi_master_core_chk #(
   parameter int CS_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            busy,
   input logic            busy_err,
   input logic            done,
   input logic            sclk,
   input logic            cpol,
   input logic [CS_W-1:0] sel_o,
   input logic [CS_W-1:0] cs_cfg
);
   // R6
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |-> $past(wr_en && busy));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cpol));

   // R7
   sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sel_o == cs_cfg));
endmodule

bind spi_master_core spi_master_core_chk #(.CS_W(CS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
   .busy_err(busy_err), .done(done), .sclk(sclk), .cpol(cpol_q),
   .sel_o(sel_o), .cs_cfg(cs_q)
);

// File: tb/spi_master_core_test.sv
module spi_master_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        inv = 1'b0;
   logic        miso;
   logic [31:0] rd_data;
   logic        busy, busy_err, done, sclk, mosi;
   logic [7:0]  sel_o;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #4 clk = ~clk;
   assign miso = mosi ^ inv;

   spi_master_core uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .miso(miso), .rd_data(rd_data), .busy(busy),
      .busy_err(busy_err), .done(done), .sclk(sclk), .mosi(mosi),
      .sel_o(sel_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(input int flags, input int n, input int div, input int cs);
      wr(1'b1, {8'(cs), 8'(div - 2), 8'(n - 1), 8'(flags)});
   endtask

   function automatic logic [31:0] model_rx(input logic [31:0] d, input int n,
                                            input bit lsb, input bit iv);
      logic [31:0] r = d;
      for (int i = 0; i < n; i++) begin
         if (lsb) r = {r[0] ^ iv, r[31:1]};
         else     r = {r[30:0], r[31] ^ iv};
      end
      return r;
   endfunction

   function automatic logic [31:0] model_tx(input logic [31:0] d, input int n,
                                            input bit lsb);
      logic [31:0] t = '0;
      for (int k = 0; k < n; k++) t[k] = lsb ? d[k] : d[31 - k];
      return t;
   endfunction

   // Watches one transfer from the first busy cycle until busy falls.
   task automatic observe(input bit cpol, input bit cpha, output int cycles,
                          output int lead, output int act_len,
                          output logic [31:0] cap, output logic [7:0] sel_run);
      logic prev = cpol;
      int   k = 0;
      int   cur = 0;
      cycles = 0; lead = 0; act_len = 0; cap = '0; sel_run = sel_o;
      while (busy && cycles < 100000) begin
         if (sclk != prev) begin
            if (sclk != cpol) lead++;
            if (((cpha == 1'b0) && (sclk != cpol)) || ((cpha == 1'b1) && (sclk == cpol))) begin
               if (k < 32) cap[k] = mosi;
               k++;
            end
         end
         if (sclk != cpol) cur++;
         else if (cur != 0 && act_len == 0) act_len = cur;
         prev = sclk;
         cycles++;
         @(negedge clk);
      end
      if (act_len == 0) act_len = cur;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int cyc, lead, alen;
      logic [31:0] cap, d;
      logic [7:0] srun;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "sel after reset", sel_o, 0);
      chk("R10", "sclk idle after reset", sclk, 0);
      chk("R1", "rd_data after reset", rd_data, 0);
      chk("R9", "done after reset", done, 0);

      // R1 default length 1 and divider 2: 4 busy cycles
      wr(1'b0, 32'h8000_0001);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R1", "default duration", cyc, 4);
      chk("R3", "default edge count", lead, 1);
      chk("R5", "default rx", rd_data, model_rx(32'h8000_0001, 1, 0, 0));
      chk("R7", "park without end flag keeps pattern 0", sel_o, 0);

      // R1 field placement: chained from park, length 3, divider 3
      cfg(1, 3, 3, 8'h5A);
      wr(1'b0, 32'hA000_0000);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R1", "field layout chained duration", cyc, 9);
      chk("R7", "select during run", srun, 8'h5A);
      chk("R8", "select released", sel_o, 0);

      // Sweep: modes x divider x length
      for (int cpha = 0; cpha < 2; cpha++)
      for (int cpol = 0; cpol < 2; cpol++)
      for (int lsb = 0; lsb < 2; lsb++)
      for (int div = 2; div <= 5; div++)
      for (int ni = 0; ni < 4; ni++) begin
         int n;
         n = (ni == 0) ? 1 : (ni == 1) ? 5 : (ni == 2) ? 8 : 32;
         inv = div[0];
         d = 32'hC3A5_0F96 ^ (32'(n) * 32'h0101_0101) ^ (32'(div) << 20);
         cfg(1 | (lsb << 1) | (cpol << 2) | (cpha << 3), n, div, 8'h3C);
         chk("R10", "sclk idle level before start", sclk, 64'(cpol));
         wr(1'b0, d);
         observe(cpol[0], cpha[0], cyc, lead, alen, cap, srun);
         chk("R3", "standalone duration", cyc, 64'((n + 1) * div));
         chk("R3", "leading edges", lead, 64'(n));
         chk("R2", "active half length", alen,
             64'(cpha ? (div + 1) / 2 : div / 2));
         chk("R4", "bits at capture edge", cap, model_tx(d, n, lsb[0]));
         chk("R5", "received word", rd_data, model_rx(d, n, lsb[0], inv));
         if (n == 32 && !inv) chk("R5", "recirculation", rd_data, d);
         chk("R7", "select during run", srun, 8'h3C);
         chk("R9", "done at busy fall", done, 1);
         chk("R8", "select released", sel_o, 0);
         @(negedge clk);
         chk("R9", "done single cycle", done, 0);
      end
      inv = 1'b0;

      // R7 chaining
      cfg(0, 8, 4, 8'hA5);
      wr(1'b0, 32'h1234_5678);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R3", "first of chain", cyc, 36);
      chk("R7", "select parked", sel_o, 8'hA5);
      chk("R7", "busy low while parked", busy, 0);
      wr(1'b0, 32'h9ABC_DEF0);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R7", "chained duration", cyc, 32);
      chk("R7", "select still parked", sel_o, 8'hA5);
      cfg(1, 8, 4, 8'hA5);
      wr(1'b0, 32'h0F0F_3355);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R7", "last chained duration", cyc, 32);
      chk("R8", "select released after end", sel_o, 0);
      chk("R5", "chained rx", rd_data, model_rx(32'h0F0F_3355, 8, 0, 0));

      // R6 writes while busy are dropped
      cfg(1, 8, 4, 8'h11);
      wr(1'b0, 32'hDEAD_BEEF);
      cyc = 0;
      while (busy && cyc < 1000) begin
         if (cyc == 3) begin
            wr_addr = 1'b1; wr_data = 32'h0000_0001; wr_en = 1'b1;
         end else if (cyc == 4) begin
            wr_en = 1'b0;
            chk("R6", "error strobe after config write", busy_err, 1);
         end else if (cyc == 5) begin
            chk("R6", "error strobe one cycle", busy_err, 0);
            wr_addr = 1'b0; wr_data = 32'h0; wr_en = 1'b1;
         end else if (cyc == 6) begin
            wr_en = 1'b0;
            chk("R6", "error strobe after data write", busy_err, 1);
         end
         cyc++;
         @(negedge clk);
      end
      chk("R6", "duration unaffected", cyc, 36);
      chk("R6", "data unaffected", rd_data, model_rx(32'hDEAD_BEEF, 8, 0, 0));
      wr(1'b0, 32'h0000_00FF);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R6", "config kept after dropped write", cyc, 36);
      chk("R6", "pattern kept", srun, 8'h11);

      // R2 largest divider
      cfg(1, 1, 257, 0);
      wr(1'b0, 32'h8000_0000);
      observe(1'b0, 1'b0, cyc, lead, alen, cap, srun);
      chk("R3", "divider 257 duration", cyc, 514);
      chk("R2", "divider 257 hold half", alen, 128);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule